// File: doc/BRIEF.md
# Flash Command Sequencer with Split Secure and Non-Secure Register Sets

This block sits between a simple synchronous register bus and an embedded flash array. It carries two independent register domains, non-secure (bus address bit 2 = 0) and secure (bus address bit 2 = 1). Each domain has a key register, a control register and a status register. A domain's control register accepts writes only after software has unlocked it with two keys written in a fixed order. Software then selects a page erase or a per-bank mass erase and sets the start bit. The sequencer checks the request and hands it to the array through a one-cycle start pulse. It reports busy, end-of-operation and error flags back into the requesting domain's status register.

The array is a behavioural model inside the block. It finishes each operation a fixed number of cycles after the start pulse; that number is set by `OP_LATENCY`. The parameter `DUAL_BANK` selects how the page number and bank bit are decoded. Both domains share the one array, so each domain's busy bit shows the array sequencer's state.

Each domain has a lock state machine with four states:
- `LK_WAIT_A`: locked, expecting the first key.
- `LK_WAIT_B`: locked, expecting the second key.
- `LK_OPEN`: unlocked.
- `LK_JAMMED`: locked until reset.

A correct first key moves `LK_WAIT_A` to `LK_WAIT_B`. A correct second key moves `LK_WAIT_B` to `LK_OPEN`. Any wrong key in either waiting state moves to `LK_JAMMED`. A relock write moves `LK_OPEN` back to `LK_WAIT_A`.

The command sequencer has four states:
- `SQ_IDLE`: no operation running.
- `SQ_LAUNCH`: drives the start pulse.
- `SQ_WAIT`: waits for the array to report completion.
- `SQ_FINISH`: sets end-of-operation.

`SQ_IDLE` moves to `SQ_LAUNCH` when a start is pending, the checks pass and the array is idle. `SQ_LAUNCH` always moves to `SQ_WAIT`. `SQ_WAIT` moves to `SQ_FINISH` when the array reports done. `SQ_FINISH` always returns to `SQ_IDLE`.

Top module: `flash_cmd_seq`

## Requirements

Register addresses within a domain (bus address bits 1:0): 0 is the key register, 1 is the control register, 2 is the status register.

Control register bits: bit 0 start, bit 1 program mode, bit 2 page erase, bit 3 mass-erase bank 0, bit 4 mass-erase bank 1, bit 5 bank select, bits 15:8 page number, bit 31 lock.

Status register bits: bit 0 busy, bit 1 end-of-operation, bit 2 sequence error, bit 4 alignment error, bit 7 operation error. Bits 3, 5 and 6 (size, write-protect and program errors) always read 0.

- R1: After reset, both control registers read 0x80000000 (locked, all fields 0) and both status registers read 0.
- R2: A domain unlocks (control bit 31 reads 0) only after 0x45670123 and then 0xCDEF89AB are written to that domain's key register. Unlocking one domain leaves the other locked.
- R3: A wrong key value, or the second key written first, leaves the domain locked until reset. Any later key write is rejected, including the correct sequence.
- R4: Control writes to a locked domain are ignored. While unlocked, a control write with bit 31 set relocks the domain, clears every control field and discards the rest of that write.
- R5: Start with page erase launches exactly one `arr_start` pulse with `arr_kind` = 1. In dual-bank mode the bank is bit 5 and the page is field bits 15:8. In single-bank mode the field indexes both banks in sequence (bank = field >= pages per bank). In single-bank mode, bit 5 set gives a sequence error and no launch.
- R6: Start with mass erase launches one pulse with `arr_kind` = 2 and `arr_mass` equal to {bit 4, bit 3}. Both bits set erases the whole array.
- R7: Busy reads 1 from the cycle after an accepted start until the array finishes. End-of-operation then reads 1 in the requesting domain.
- R8: A start written while busy reads 1 is ignored (no extra pulse) and sets the operation-error bit.
- R9: A start while any error bit of that domain is still set raises the sequence error and does not launch.
- R10: A start with no erase selected, with both page and mass erase selected, or with program mode set raises the sequence error. A page beyond the array raises the alignment error. Neither launches.
- R11: Status bits 1, 2, 4 and 7 clear only when 1 is written to them; writing 0 leaves them unchanged.
- R12: The start bit reads 0 once the start has been accepted or rejected.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address: bit 2 selects the domain, bits 1:0 select the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| arr_start | output | 1 | One-cycle launch pulse to the array |
| arr_kind | output | 2 | Operation kind: 1 page erase, 2 mass erase |
| arr_page | output | log2(PAGES_PER_BANK) | Page within the selected bank |
| arr_bank | output | 1 | Bank of a page erase |
| arr_mass | output | 2 | Per-bank mass-erase mask |

## Verification

The assertions assume the following about the inputs:
- Reset is held from time zero.
- `bus_addr` and `bus_wdata` are defined whenever `bus_we` is high.
- Every write is a single-cycle strobe.

The stimulus keeps within these limits: it changes inputs only on falling clock edges, holds `bus_we` for exactly one cycle per write, and issues no write while reset is asserted.

The directed scenarios walk each domain through every lock state and every sequencer transition. A second instance built with `DUAL_BANK = 0` covers single-bank decoding.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;

    localparam logic [31:0] UNLOCK_KEY_A = 32'h4567_0123;
    localparam logic [31:0] UNLOCK_KEY_B = 32'hCDEF_89AB;

    localparam logic [1:0] REG_KEY  = 2'd0;
    localparam logic [1:0] REG_CTRL = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;

    localparam int PAGE_FIELD_W = 8;
    localparam int CB_GO   = 0;
    localparam int CB_PGM  = 1;
    localparam int CB_PER  = 2;
    localparam int CB_MER0 = 3;
    localparam int CB_MER1 = 4;
    localparam int CB_BSEL = 5;
    localparam int CB_PLO  = 8;
    localparam int CB_LOCK = 31;

    localparam int SB_BUSY  = 0;
    localparam int SB_EOP   = 1;
    localparam int SB_SEQ   = 2;
    localparam int SB_ALIGN = 4;
    localparam int SB_OP    = 7;

    typedef enum logic [1:0] {LK_WAIT_A, LK_WAIT_B, LK_OPEN, LK_JAMMED} lock_state_e;
    typedef enum logic [1:0] {SQ_IDLE, SQ_LAUNCH, SQ_WAIT, SQ_FINISH} seq_state_e;
    typedef enum logic [1:0] {OP_NONE = 2'd0, OP_PAGE = 2'd1, OP_MASS = 2'd2} op_kind_e;
    typedef enum logic [1:0] {VD_RUN, VD_SEQ, VD_ALIGN} verdict_e;

    typedef struct packed {
        logic                    pgm;
        logic                    per;
        logic [1:0]              mer;
        logic                    bsel;
        logic [PAGE_FIELD_W-1:0] page;
    } ctrl_fields_t;

    function automatic ctrl_fields_t ctrl_from_word(input logic [31:0] w);
        ctrl_fields_t f;
        f.pgm  = w[CB_PGM];
        f.per  = w[CB_PER];
        f.mer  = {w[CB_MER1], w[CB_MER0]};
        f.bsel = w[CB_BSEL];
        f.page = w[CB_PLO +: PAGE_FIELD_W];
        return f;
    endfunction

    function automatic logic [31:0] ctrl_to_word(input ctrl_fields_t f, input logic lock,
                                                 input logic go);
        logic [31:0] w;
        w = '0;
        w[CB_GO]   = go;
        w[CB_PGM]  = f.pgm;
        w[CB_PER]  = f.per;
        w[CB_MER0] = f.mer[0];
        w[CB_MER1] = f.mer[1];
        w[CB_BSEL] = f.bsel;
        w[CB_PLO +: PAGE_FIELD_W] = f.page;
        w[CB_LOCK] = lock;
        return w;
    endfunction

    function automatic logic [31:0] stat_to_word(input logic busy, input logic eop,
                                                 input logic seq, input logic align,
                                                 input logic op);
        logic [31:0] w;
        w = '0;
        w[SB_BUSY]  = busy;
        w[SB_EOP]   = eop;
        w[SB_SEQ]   = seq;
        w[SB_ALIGN] = align;
        w[SB_OP]    = op;
        return w;
    endfunction

endpackage

// File: rtl/flash_key_fsm.sv
`timescale 1ns/1ps
module flash_key_fsm
    import flash_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_we,
    input  logic [31:0] key_val,
    input  logic        relock,
    output logic        unlocked
);

    lock_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_WAIT_A;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_WAIT_A: if (key_we) state_d = (key_val == UNLOCK_KEY_A) ? LK_WAIT_B : LK_JAMMED;
            LK_WAIT_B: if (key_we) state_d = (key_val == UNLOCK_KEY_B) ? LK_OPEN : LK_JAMMED;
            LK_OPEN:   if (relock) state_d = LK_WAIT_A;
            LK_JAMMED: state_d = LK_JAMMED;
        endcase
    end

    assign unlocked = (state_q == LK_OPEN);

endmodule

// File: rtl/flash_op_decode.sv
`timescale 1ns/1ps
module flash_op_decode
    import flash_seq_pkg::*;
#(
    parameter int DUAL_BANK      = 1,
    parameter int PAGES_PER_BANK = 128
)(
    input  ctrl_fields_t                      fields,
    input  logic                              stale_err,
    output verdict_e                          verdict,
    output op_kind_e                          kind,
    output logic [$clog2(PAGES_PER_BANK)-1:0] page,
    output logic                              bank
);

    localparam int PAGE_W = $clog2(PAGES_PER_BANK);

    logic in_range;
    logic bsel_bad;
    logic mer_any;

    assign mer_any = |fields.mer;

    generate
        if (DUAL_BANK != 0) begin : g_dual
            assign in_range = ({1'b0, fields.page} < 9'(PAGES_PER_BANK));
            assign bank     = fields.bsel;
            assign bsel_bad = 1'b0;
        end else begin : g_single
            assign in_range = ({1'b0, fields.page} < 9'(2 * PAGES_PER_BANK));
            assign bank     = fields.page[PAGE_W];
            assign bsel_bad = fields.bsel;
        end
    endgenerate

    assign page = fields.page[PAGE_W-1:0];
    assign kind = fields.per ? OP_PAGE : OP_MASS;

    always_comb begin
        if (stale_err)
            verdict = VD_SEQ;
        else if (fields.pgm || (fields.per == mer_any) || (fields.per && bsel_bad))
            verdict = VD_SEQ;
        else if (fields.per && !in_range)
            verdict = VD_ALIGN;
        else
            verdict = VD_RUN;
    end

endmodule

// File: rtl/flash_array_model.sv
`timescale 1ns/1ps
module flash_array_model #(
    parameter int LATENCY = 6
)(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CNT_W = $clog2(LATENCY + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (start)        cnt_q <= CNT_W'(LATENCY);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int DUAL_BANK      = 1,
    parameter int PAGES_PER_BANK = 128,
    parameter int OP_LATENCY     = 6
)(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [2:0]                        bus_addr,
    input  logic [31:0]                       bus_wdata,
    input  logic                              bus_we,
    output logic [31:0]                       bus_rdata,
    output logic                              arr_start,
    output logic [1:0]                        arr_kind,
    output logic [$clog2(PAGES_PER_BANK)-1:0] arr_page,
    output logic                              arr_bank,
    output logic [1:0]                        arr_mass
);

    localparam int PAGE_W  = $clog2(PAGES_PER_BANK);
    localparam int NUM_DOM = 2;

    logic [NUM_DOM-1:0] unlocked, key_we, ctrl_we, stat_we, relock;
    logic [NUM_DOM-1:0] go_q, take_go, set_eop, set_seq, set_align, set_op;
    logic [NUM_DOM-1:0] eop_q, seq_err_q, align_err_q, op_err_q;
    ctrl_fields_t       ctrl_q [NUM_DOM];

    seq_state_e  state_q, state_d;
    logic        busy_any;
    logic        req_any, req_dom, accept;
    ctrl_fields_t req_fields;
    logic        req_stale;
    verdict_e    verdict;
    op_kind_e    dec_kind;
    logic [PAGE_W-1:0] dec_page;
    logic        dec_bank;

    logic              owner_q;
    op_kind_e          kind_q;
    logic [PAGE_W-1:0] page_q;
    logic              bank_q;
    logic [1:0]        mass_q;
    logic              arr_busy, arr_done;

    assign busy_any = (state_q != SQ_IDLE);

    generate
        for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
            logic dom_hit;
            assign dom_hit    = (bus_addr[2] == 1'(d));
            assign key_we[d]  = bus_we && dom_hit && (bus_addr[1:0] == REG_KEY);
            assign ctrl_we[d] = bus_we && dom_hit && (bus_addr[1:0] == REG_CTRL);
            assign stat_we[d] = bus_we && dom_hit && (bus_addr[1:0] == REG_STAT);
            assign relock[d]  = ctrl_we[d] && unlocked[d] && bus_wdata[CB_LOCK];
            assign set_op[d]  = ctrl_we[d] && unlocked[d] && !bus_wdata[CB_LOCK]
                                && bus_wdata[CB_GO] && busy_any;

            flash_key_fsm u_key (
                .clk      (clk),
                .rst_n    (rst_n),
                .key_we   (key_we[d]),
                .key_val  (bus_wdata),
                .relock   (relock[d]),
                .unlocked (unlocked[d])
            );

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ctrl_q[d] <= '0;
                    go_q[d]   <= 1'b0;
                end else if (relock[d]) begin
                    ctrl_q[d] <= '0;
                    go_q[d]   <= 1'b0;
                end else if (ctrl_we[d] && unlocked[d]) begin
                    ctrl_q[d] <= ctrl_from_word(bus_wdata);
                    go_q[d]   <= bus_wdata[CB_GO] && !busy_any;
                end else if (take_go[d]) begin
                    go_q[d]   <= 1'b0;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    eop_q[d]       <= 1'b0;
                    seq_err_q[d]   <= 1'b0;
                    align_err_q[d] <= 1'b0;
                    op_err_q[d]    <= 1'b0;
                end else begin
                    if (set_eop[d])                               eop_q[d] <= 1'b1;
                    else if (stat_we[d] && bus_wdata[SB_EOP])     eop_q[d] <= 1'b0;
                    if (set_seq[d])                               seq_err_q[d] <= 1'b1;
                    else if (stat_we[d] && bus_wdata[SB_SEQ])     seq_err_q[d] <= 1'b0;
                    if (set_align[d])                             align_err_q[d] <= 1'b1;
                    else if (stat_we[d] && bus_wdata[SB_ALIGN])   align_err_q[d] <= 1'b0;
                    if (set_op[d])                                op_err_q[d] <= 1'b1;
                    else if (stat_we[d] && bus_wdata[SB_OP])      op_err_q[d] <= 1'b0;
                end
            end
        end
    endgenerate

    // Request selection: the non-secure domain wins a same-cycle tie.
    assign req_any    = |go_q;
    assign req_dom    = !go_q[0];
    assign req_fields = ctrl_q[req_dom];
    assign req_stale  = seq_err_q[req_dom] | align_err_q[req_dom] | op_err_q[req_dom];

    flash_op_decode #(
        .DUAL_BANK      (DUAL_BANK),
        .PAGES_PER_BANK (PAGES_PER_BANK)
    ) u_dec (
        .fields    (req_fields),
        .stale_err (req_stale),
        .verdict   (verdict),
        .kind      (dec_kind),
        .page      (dec_page),
        .bank      (dec_bank)
    );

    assign accept = (state_q == SQ_IDLE) && req_any && !arr_busy;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:   if (accept && verdict == VD_RUN) state_d = SQ_LAUNCH;
            SQ_LAUNCH: state_d = SQ_WAIT;
            SQ_WAIT:   if (arr_done) state_d = SQ_FINISH;
            SQ_FINISH: state_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        take_go   = '0;
        set_seq   = '0;
        set_align = '0;
        set_eop   = '0;
        if (accept) begin
            take_go[req_dom]   = 1'b1;
            set_seq[req_dom]   = (verdict == VD_SEQ);
            set_align[req_dom] = (verdict == VD_ALIGN);
        end
        if (state_q == SQ_FINISH) set_eop[owner_q] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= 1'b0;
            kind_q  <= OP_NONE;
            page_q  <= '0;
            bank_q  <= 1'b0;
            mass_q  <= '0;
        end else if (accept && verdict == VD_RUN) begin
            owner_q <= req_dom;
            kind_q  <= dec_kind;
            page_q  <= dec_page;
            bank_q  <= dec_bank;
            mass_q  <= req_fields.per ? 2'b00 : req_fields.mer;
        end
    end

    assign arr_start = (state_q == SQ_LAUNCH);
    assign arr_kind  = kind_q;
    assign arr_page  = page_q;
    assign arr_bank  = bank_q;
    assign arr_mass  = mass_q;

    flash_array_model #(.LATENCY(OP_LATENCY)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .start (arr_start),
        .busy  (arr_busy),
        .done  (arr_done)
    );

    always_comb begin
        unique case (bus_addr[1:0])
            REG_CTRL: bus_rdata = ctrl_to_word(ctrl_q[bus_addr[2]], !unlocked[bus_addr[2]],
                                               go_q[bus_addr[2]]);
            REG_STAT: bus_rdata = stat_to_word(busy_any, eop_q[bus_addr[2]],
                                               seq_err_q[bus_addr[2]],
                                               align_err_q[bus_addr[2]],
                                               op_err_q[bus_addr[2]]);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/flash_cmd_seq_sva.sv
`timescale 1ns/1ps
module flash_cmd_seq_sva
    import flash_seq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_we,
    input logic        arr_start,
    input logic [1:0]  arr_kind,
    input logic [1:0]  arr_mass,
    input logic [1:0]  unlocked,
    input logic        busy_any,
    input logic        arr_busy,
    input logic        arr_done
);

    AST_NS_UNLOCK_AFTER_KEY_B: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked[0]) |-> $past(bus_we && bus_addr == 3'd0 && bus_wdata == UNLOCK_KEY_B)); // R2

    AST_SEC_UNLOCK_AFTER_KEY_B: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked[1]) |-> $past(bus_we && bus_addr == 3'd4 && bus_wdata == UNLOCK_KEY_B)); // R2

    AST_START_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |=> !arr_start); // R5

    AST_START_ONLY_ARRAY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |-> !arr_busy); // R8

    AST_BUSY_ENDS_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_any) |-> $past(arr_done, 2)); // R7

    AST_MASS_SELECTS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_start && arr_kind == 2'(OP_MASS)) |-> (arr_mass != 2'b00)); // R6

endmodule

bind flash_cmd_seq flash_cmd_seq_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .arr_start (arr_start),
    .arr_kind  (arr_kind),
    .arr_mass  (arr_mass),
    .unlocked  (unlocked),
    .busy_any  (busy_any),
    .arr_busy  (arr_busy),
    .arr_done  (arr_done)
);

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;

    localparam int PAGES = 128;
    localparam int PW    = $clog2(PAGES);
    localparam logic [31:0] KA = 32'h4567_0123;
    localparam logic [31:0] KB = 32'hCDEF_89AB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic we_m = 1'b0, we_s = 1'b0;
    logic [31:0] rdata_m, rdata_s;
    logic start_m, start_s, bank_m, bank_s;
    logic [1:0] kind_m, kind_s, mass_m, mass_s;
    logic [PW-1:0] page_m, page_s;

    int tests = 0;
    int fails = 0;
    int nst_m = 0, nst_s = 0;
    logic [1:0] lk_m, lk_s, lm_m, lm_s;
    logic [PW-1:0] lp_m, lp_s;
    logic lb_m, lb_s;
    bit finished = 0;

    always #10 clk = ~clk;

    flash_cmd_seq #(.DUAL_BANK(1), .PAGES_PER_BANK(PAGES), .OP_LATENCY(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(we_m),
        .bus_rdata(rdata_m), .arr_start(start_m), .arr_kind(kind_m), .arr_page(page_m),
        .arr_bank(bank_m), .arr_mass(mass_m));

    flash_cmd_seq #(.DUAL_BANK(0), .PAGES_PER_BANK(PAGES), .OP_LATENCY(4)) dut_single_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(we_s),
        .bus_rdata(rdata_s), .arr_start(start_s), .arr_kind(kind_s), .arr_page(page_s),
        .arr_bank(bank_s), .arr_mass(mass_s));

    always @(negedge clk) begin
        if (start_m) begin nst_m++; lk_m = kind_m; lp_m = page_m; lb_m = bank_m; lm_m = mass_m; end
        if (start_s) begin nst_s++; lk_s = kind_s; lp_s = page_s; lb_s = bank_s; lm_s = mass_s; end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input bit s, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d;
        if (s) we_s = 1'b1; else we_m = 1'b1;
        @(negedge clk);
        we_m = 1'b0; we_s = 1'b0;
    endtask

    task automatic rd(input bit s, input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = s ? rdata_s : rdata_m;
    endtask

    task automatic wait_idle(input bit s, input logic [2:0] base);
        logic [31:0] v;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            rd(s, base + 3'd2, v);
            if (!v[0]) break;
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(0, 3'd1, v); chk("R1 ns ctrl", v, 32'h8000_0000);
        rd(0, 3'd5, v); chk("R1 sec ctrl", v, 32'h8000_0000);
        rd(0, 3'd2, v); chk("R1 ns status", v, 32'h0);
        rd(0, 3'd6, v); chk("R1 sec status", v, 32'h0);
    endtask

    task automatic t_locked_ignore_and_unlock;
        logic [31:0] v;
        wr(0, 3'd1, 32'h0000_0405);
        repeat (3) @(negedge clk);
        rd(0, 3'd1, v); chk("R4 locked write ignored", v, 32'h8000_0000);
        chk("R4 no launch while locked", nst_m, 0);
        wr(0, 3'd0, KA); wr(0, 3'd0, KB);
        rd(0, 3'd1, v); chk("R2 ns unlocked", v, 32'h0);
        rd(0, 3'd5, v); chk("R2 sec still locked", v, 32'h8000_0000);
    endtask

    task automatic t_page_erase_dual;
        logic [31:0] v;
        wr(0, 3'd1, 32'h0000_2525);
        @(negedge clk);
        rd(0, 3'd2, v); chk("R7 busy after start", v[0], 1'b1);
        rd(0, 3'd1, v); chk("R12 start bit self-clears", v[0], 1'b0);
        wait_idle(0, 3'd0);
        chk("R5 one pulse", nst_m, 1);
        chk("R5 kind page", lk_m, 2'd1);
        chk("R5 dual page", lp_m, 7'h25);
        chk("R5 dual bank", lb_m, 1'b1);
        rd(0, 3'd2, v); chk("R7 eop set, busy clear", v, 32'h2);
        rd(0, 3'd6, v); chk("R7 eop only in owner", v, 32'h0);
        wr(0, 3'd2, 32'h2);
        rd(0, 3'd2, v); chk("R7 eop cleared", v, 32'h0);
    endtask

    task automatic t_mass_and_busy_start;
        logic [31:0] v;
        wr(0, 3'd1, 32'h0000_0019);
        @(negedge clk);
        wr(0, 3'd1, 32'h0000_0019);
        wait_idle(0, 3'd0);
        repeat (3) @(negedge clk);
        chk("R8 busy start ignored", nst_m, 2);
        chk("R6 kind mass", lk_m, 2'd2);
        chk("R6 whole array", lm_m, 2'b11);
        rd(0, 3'd2, v); chk("R8 op error set", v, 32'h82);
    endtask

    task automatic t_stale_and_w1c;
        logic [31:0] v;
        wr(0, 3'd1, 32'h0000_0305);
        repeat (4) @(negedge clk);
        chk("R9 stale error blocks launch", nst_m, 2);
        rd(0, 3'd2, v); chk("R9 seq error raised", v, 32'h86);
        rd(0, 3'd1, v); chk("R12 rejected start clears", v[0], 1'b0);
        wr(0, 3'd2, 32'h0);
        rd(0, 3'd2, v); chk("R11 write 0 keeps flags", v, 32'h86);
        wr(0, 3'd2, 32'h86);
        rd(0, 3'd2, v); chk("R11 write 1 clears", v, 32'h0);
    endtask

    task automatic t_invalid;
        logic [31:0] v;
        wr(0, 3'd1, 32'h0000_0001);
        repeat (2) @(negedge clk);
        rd(0, 3'd2, v); chk("R10 nothing selected", v, 32'h4);
        wr(0, 3'd2, 32'h4);
        wr(0, 3'd1, 32'h0000_0007);
        repeat (2) @(negedge clk);
        rd(0, 3'd2, v); chk("R10 program mode set", v, 32'h4);
        wr(0, 3'd2, 32'h4);
        wr(0, 3'd1, 32'h0000_000D);
        repeat (2) @(negedge clk);
        rd(0, 3'd2, v); chk("R10 page and mass", v, 32'h4);
        wr(0, 3'd2, 32'h4);
        wr(0, 3'd1, 32'h0000_C805);
        repeat (2) @(negedge clk);
        rd(0, 3'd2, v); chk("R10 page out of range", v, 32'h10);
        wr(0, 3'd2, 32'h10);
        chk("R10 no launch", nst_m, 2);
    endtask

    task automatic t_relock;
        logic [31:0] v;
        wr(0, 3'd1, 32'h8000_0004);
        rd(0, 3'd1, v); chk("R4 relock clears fields", v, 32'h8000_0000);
        wr(0, 3'd1, 32'h0000_0004);
        rd(0, 3'd1, v); chk("R4 write after relock ignored", v, 32'h8000_0000);
        wr(0, 3'd0, KA); wr(0, 3'd0, KB);
        rd(0, 3'd1, v); chk("R2 unlock again", v, 32'h0);
    endtask

    task automatic t_jam;
        logic [31:0] v;
        wr(0, 3'd4, 32'h1234_5678);
        wr(0, 3'd4, KA); wr(0, 3'd4, KB);
        rd(0, 3'd5, v); chk("R3 wrong key jams", v, 32'h8000_0000);
        wr(1, 3'd4, KB); wr(1, 3'd4, KA); wr(1, 3'd4, KB);
        rd(1, 3'd5, v); chk("R3 reversed order jams", v, 32'h8000_0000);
    endtask

    task automatic t_single_bank;
        logic [31:0] v;
        wr(1, 3'd0, KA); wr(1, 3'd0, KB);
        wr(1, 3'd1, 32'h0000_8205);
        wait_idle(1, 3'd0);
        chk("R5 single one pulse", nst_s, 1);
        chk("R5 single bank", lb_s, 1'b1);
        chk("R5 single page", lp_s, 7'h02);
        wr(1, 3'd2, 32'h2);
        wr(1, 3'd1, 32'h0000_0125);
        repeat (3) @(negedge clk);
        rd(1, 3'd2, v); chk("R5 bank bit in single mode", v, 32'h4);
        chk("R5 bank bit no launch", nst_s, 1);
        wr(1, 3'd2, 32'h4);
        wr(1, 3'd1, 32'h0000_0009);
        wait_idle(1, 3'd0);
        chk("R6 bank0 mask", lm_s, 2'b01);
        chk("R6 single pulse count", nst_s, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked_ignore_and_unlock();
        t_page_erase_dual();
        t_mass_and_busy_start();
        t_stale_and_w1c();
        t_invalid();
        t_relock();
        t_jam();
        t_single_bank();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule